// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block is the control front of a serial controller engine. Software asks for an operating state: reset, run or pause. The block carries that request from the register-bus clock domain into the engine's core clock domain through a toggle handshake. While a transition is in flight, a valid flag in the state register reads 0. It reads 1 again once the core side has applied the new state and its acknowledge has come back. Software drivers poll that flag before they write the next request.

The block also has a software-reset register and an operational flag register. The software-reset register sends the engine back to its reset state and reloads the flag register. The flag register latches event pulses from the engine (NACK, FIFO conditions, service requests, count completion). Software clears those flags by writing 1 to them. Reads return data combinationally in the cycle of the access. Event inputs are expected to be synchronous to the bus clock.

Top module: `sereng_runctl`

## Requirements
- R1: After reset, the state register (offset 0x0) reads 0x4: state code 0 and valid bit 2 set. The flag register (offset 0x8) reads 0x000FF0, and `eng_state` is 0.
- R2: The state code lives in bits 1:0 of the state register: 0 is reset, 1 is run, 3 is pause. A write of code 2 is ignored, and the register keeps its previous contents with valid still 1.
- R3: An accepted state write clears valid (bit 2) at the clock edge that takes the write. The code field shows the new value at once. Three core-clock edges later, `eng_state` takes the new code, and valid returns three bus-clock edges after that. Valid must return within 12 bus cycles of the write.
- R4: A write to the state register while valid reads 0 is ignored. The request that is already in flight completes unchanged.
- R5: Writing 1 to bit 0 at offset 0x4 reloads the flag register with 0x000FF0 and starts a transition to state code 0 through the same handshake. Valid stays 0 until that transition is done.
- R6: A software reset written while a transition is in flight is held. The reset transition starts after the current one finishes, and valid stays 0 throughout.
- R7: Flag register bits 11:3 are sticky. Bit 3 is NACK, bit 4 output not empty, bit 5 input not empty, bit 6 output full, bit 7 spare, bit 8 output service, bit 9 input service, bit 10 output count done and bit 11 input count done. Each bit is set at a clock edge where `ev_set[bit-3]` is 1.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. If an event and a clearing write arrive in the same cycle, the event wins and the bit is set.
- R9: Bit 4 of the state register mirrors the `mst_on` input. All other unlisted bits of every register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| core_clk | input | 1 | Engine core clock |
| core_rst_n | input | 1 | Active-low reset, core domain |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the access cycle |
| ev_set | input | 9 | Engine event pulses, bit i sets flag bit i+3 |
| mst_on | input | 1 | Engine reports its controller function enabled |
| eng_state | output | 2 | State code applied in the core domain |

## Verification
Some rules are checked by assertions on every cycle. Valid drops on the edge after any accepted state write. The requested code does not move while a transition is busy. A write-one clear removes a flag when no event races it. A software reset reloads 0x000FF0. The core-side state code never holds the unused value 2. Other behaviour can only be shown by the bench scenarios. These are the round trip across both clock domains within its cycle budget, the held software reset that follows an in-flight request, the ignored unused code, and the event-beats-clear race.

// File: rtl/sereng_runctl.sv
module sereng_runctl #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_clk,
  input  logic          core_rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [8:0]    ev_set,
  input  logic          mst_on,
  output logic [1:0]    eng_state
);
  localparam logic [AW-1:0] OFF_STATE = AW'(0);
  localparam logic [AW-1:0] OFF_SRST  = AW'(4);
  localparam logic [AW-1:0] OFF_FLAGS = AW'(8);
  localparam int            FLAG_LO   = 3;
  localparam logic [DW-1:0] FLAG_MASK = DW'(12'hFF8);
  localparam logic [DW-1:0] FLAG_INIT = DW'(24'h000FF0);
  localparam logic [1:0]    CODE_BAD  = 2'b10;

  logic [1:0]    state_q;
  logic          busy, srst_pend, req_tgl, ack_tgl;
  logic [2:0]    ack_sync, req_sync;
  logic [DW-1:0] flags_q;

  wire wr_any = bus_en & bus_wr;
  wire st_wr  = wr_any && (bus_addr == OFF_STATE);
  wire sr_wr  = wr_any && (bus_addr == OFF_SRST) && bus_wdata[0];
  wire fl_wr  = wr_any && (bus_addr == OFF_FLAGS);
  wire valid  = !busy && !srst_pend;
  wire st_acc = st_wr && valid && (bus_wdata[1:0] != CODE_BAD);
  wire sr_go  = !busy && (sr_wr || srst_pend);
  wire ack_ev = ack_sync[2] ^ ack_sync[1];
  wire req_ev = req_sync[2] ^ req_sync[1];
  wire [DW-1:0] ev_bits = (DW'(ev_set) << FLAG_LO) & FLAG_MASK;
  wire [DW-1:0] clr_bits = fl_wr ? (bus_wdata & FLAG_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= 2'b00;
      busy      <= 1'b0;
      srst_pend <= 1'b0;
      req_tgl   <= 1'b0;
      ack_sync  <= 3'b000;
    end else begin
      ack_sync <= {ack_sync[1:0], ack_tgl};
      if (busy && ack_ev) busy <= 1'b0;
      if (st_acc) begin
        state_q <= bus_wdata[1:0];
        busy    <= 1'b1;
        req_tgl <= ~req_tgl;
      end else if (sr_go) begin
        state_q   <= 2'b00;
        busy      <= 1'b1;
        req_tgl   <= ~req_tgl;
        srst_pend <= 1'b0;
      end else if (sr_wr) begin
        srst_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= FLAG_INIT;
    else if (sr_wr) flags_q <= FLAG_INIT | ev_bits;
    else            flags_q <= (flags_q & ~clr_bits) | ev_bits;
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      req_sync  <= 3'b000;
      eng_state <= 2'b00;
      ack_tgl   <= 1'b0;
    end else begin
      req_sync <= {req_sync[1:0], req_tgl};
      if (req_ev) begin
        eng_state <= state_q;
        ack_tgl   <= ~ack_tgl;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_STATE)
      bus_rdata = DW'({mst_on, 1'b0, valid, state_q});
    else if (bus_addr == OFF_FLAGS)
      bus_rdata = flags_q;
  end

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    st_acc |=> (bus_rdata[2] == 1'b0) || (bus_addr != OFF_STATE) || !busy == 1'b0) // R3
    else $error("valid did not drop after accepted write");
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && busy) |=> $stable(state_q)) // R4
    else $error("state request moved while busy");
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr && !sr_wr && bus_wdata[8] && !ev_set[5]) |=> !flags_q[8]) // R8
    else $error("write-one clear failed");
  AST_SRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && ev_set == 9'd0) |=> (flags_q == FLAG_INIT)) // R5
    else $error("soft reset flag reload wrong");
  AST_NO_BAD_CODE: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    eng_state != CODE_BAD) // R2
    else $error("core state holds unused code");
endmodule

// File: tb/sereng_runctl_test.sv
module sereng_runctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CORE_PERIOD = 7;

  logic        clk = 0, core_clk = 0, rst_n = 0, core_rst_n = 0;
  logic        bus_en = 0, bus_wr = 0, mst_on = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [8:0]  ev_set = 0;
  logic [1:0]  eng_state;

  int tests = 0, fails = 0;
  logic        mon_on = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CORE_PERIOD/2.0) core_clk = ~core_clk;

  sereng_runctl uut (.clk(clk), .rst_n(rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ev_set(ev_set), .mst_on(mst_on), .eng_state(eng_state));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [8:0] ev = 0);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; ev_set = ev;
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0; ev_set = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_en = 1; bus_wr = 0; bus_addr = a; mon_on = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_en = 0; mon_on = 0;
  endtask

  task automatic wait_valid(input string tag);
    int n = 0;
    bus_addr = 0;
    while (n < 12) begin
      n++;
      @(negedge clk);
      if (bus_rdata[2]) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    check({tag, " valid returns within 12 cycles"}, 32'(n <= 11), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; core_rst_n = 1;
    @(posedge clk); #1;
    rd(4'h0, 32'h4, "R1 state reset");
    rd(4'h8, 32'hFF0, "R1 flags reset");
    check("R1 eng_state reset", 32'(eng_state), 0);

    wr(4'h0, 32'h1);
    rd(4'h0, 32'h1, "R3 valid drops, code shown");
    wait_valid("R3");
    check("R3 eng_state run", 32'(eng_state), 1);
    rd(4'h0, 32'h5, "R2 run code valid");

    wr(4'h0, 32'h3);
    wr(4'h0, 32'h0);
    wait_valid("R4");
    rd(4'h0, 32'h7, "R4 busy write ignored");
    check("R4 eng_state pause", 32'(eng_state), 3);

    wr(4'h0, 32'h2);
    rd(4'h0, 32'h7, "R2 code 2 ignored");
    repeat (10) @(posedge clk); #1;
    check("R2 eng_state unchanged", 32'(eng_state), 3);

    mst_on = 1;
    rd(4'h0, 32'h17, "R9 master bit");
    mst_on = 0;
    rd(4'h4, 32'h0, "R9 unlisted offset");

    wr(4'h8, 32'h100);
    rd(4'h8, 32'hEF0, "R8 clear bit 8");
    wr(4'h8, 32'h200);
    rd(4'h8, 32'hCF0, "R8 clear bit 9");
    wr(4'h8, 32'h0);
    rd(4'h8, 32'hCF0, "R8 write 0 no effect");
    @(posedge clk); ev_set = 9'h020; #1; @(posedge clk); #1; ev_set = 0;
    rd(4'h8, 32'hDF0, "R7 event sets bit 8");
    wr(4'h8, 32'h008, 9'h001);
    rd(4'h8, 32'hDF8, "R8 event beats clear bit 3");

    wr(4'h8, 32'hFF8);
    wr(4'h4, 32'h1);
    rd(4'h8, 32'hFF0, "R5 flags reload");
    rd(4'h0, 32'h0, "R5 reset launched, valid low");
    wait_valid("R5");
    check("R5 eng_state reset", 32'(eng_state), 0);

    wr(4'h0, 32'h1);
    wr(4'h4, 32'h1);
    rd(4'h0, 32'h1, "R6 held, valid low");
    repeat (4) @(posedge clk); #1;
    rd(4'h0, 32'h0, "R6 still not valid");
    wait_valid("R6");
    rd(4'h0, 32'h4, "R6 final state reset");
    check("R6 eng_state reset", 32'(eng_state), 0);

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule